// File: doc/BRIEF.md
# Scratchpad EEPROM Command Controller

This block is the memory-command layer of a serial EEPROM slave that talks over one wire. A lower bit-slot layer hands it whole received bytes and a bus-reset indication. It gives back the byte that the master reads next. The block holds a single 32-byte data page and a 32-byte scratchpad in registers. The master fills the scratchpad, reads it back to verify it, and then commits it to the page with a keyed copy command. A copy always moves the whole scratchpad. Committing starts a programming interval, which is modelled as a fixed number of clock cycles and marked by a busy output.

The read-memory command first reloads the scratchpad from the page. It then streams bytes from a start address, and the address wraps at the end of the page. The stream has no end: only a bus reset stops it. The block also decodes a write-scratchpad command and a read-scratchpad command. An unknown command code parks the controller until the next bus reset.

Top module: `scratch_eeprom_ctrl`

## Requirements
- R1: After rst_n is released, prog_busy and tx_valid are 0, and every byte of the page and of the scratchpad is 00h.
- R2: Command 0Fh takes a start address byte. Each later byte is written to the scratchpad at the current address, and the address then increments, wrapping from 1Fh to 00h.
- R3: Command AAh takes a start address byte and then streams the scratchpad. tx_valid is 1 and tx_byte shows the byte at the current address. Each tx_ack pulse advances the address, wrapping from 1Fh to 00h.
- R4: Only the low 5 bits of an address byte are used. For example, FDh selects address 1Dh.
- R5: Command 55h followed by the key byte A5h copies all 32 scratchpad bytes into the page.
- R6: After 55h, any key byte other than A5h leaves the page unchanged. The controller then accepts a new command without a bus reset.
- R7: prog_busy rises in the cycle after the A5h key is accepted and stays high for exactly PROG_CYCLES cycles. Bus resets and received bytes during that interval are ignored.
- R8: Command F0h copies the whole page into the scratchpad as soon as the command byte arrives. The next byte is a start address, and the scratchpad then streams as in R3 with no end until a bus reset.
- R9: A bus reset that arrives right after F0h, with no address byte, still leaves the scratchpad equal to the page.
- R10: Any other command code puts the controller in a parked state. There it ignores all bytes and never streams, until a bus reset.
- R11: Outside programming, bus_reset returns the controller to waiting for a command and drops tx_valid. It takes priority over a byte received in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | Bus reset indication from the bit-slot layer, one cycle |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_ack | input | 1 | The master has read tx_byte; advance the address |
| tx_valid | output | 1 | Controller is streaming bytes to the master |
| tx_byte | output | 8 | Byte for the master to read, FFh when not streaming |
| prog_busy | output | 1 | Programming interval in progress |

## Verification
Each copy fills the scratchpad with a pattern generated from a different seed. A stale page can therefore never match a fresh one. Streams start at several offsets, including one that crosses 1Fh, and they run past 32 bytes so that the wrap shows up in the returned data. Key handling is tested with a wrong key followed at once by a new command, which separates "cancel" from "park". A bus reset sent while programming, together with write bytes, shows that the interval cannot be cut short and that nothing leaks into the scratchpad. Reloading without an address, an unknown code followed by commands that would have had an effect, and a reset in the same cycle as a byte each check a separate ordering rule.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_KEY,
    ST_PROG,
    ST_RADDR,
    ST_WADDR,
    ST_WDATA,
    ST_STREAM,
    ST_HALT
  } scp_state_e;

  localparam logic [7:0] OP_READ_MEM  = 8'hF0;
  localparam logic [7:0] OP_COPY      = 8'h55;
  localparam logic [7:0] OP_WRITE_SP  = 8'h0F;
  localparam logic [7:0] OP_READ_SP   = 8'hAA;
  localparam logic [7:0] COPY_KEY     = 8'hA5;

endpackage

// File: rtl/scp_store.sv
module scp_store #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_to_sp,
  input  logic              sp_to_pg,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  logic [DEPTH-1:0][7:0] page_q;
  logic [DEPTH-1:0][7:0] spad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (sp_to_pg) begin
      page_q <= spad_q;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_spad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        spad_q[i] <= '0;
      end else if (pg_to_sp) begin
        spad_q[i] <= page_q[i];
      end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
        spad_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = spad_q[rd_addr];

  // R5
  copy_whole_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_to_pg |=> (page_q == $past(spad_q)));

  // R8
  reload_whole_spad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_to_sp |=> (spad_q == $past(page_q)));

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_to_pg |=> $stable(page_q));

endmodule

// File: rtl/scp_prog_timer.sv
module scp_prog_timer #(
  parameter int PROG_CYCLES = 1000,
  parameter int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(PROG_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R7
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/scp_fsm.sv
module scp_fsm
  import scp_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ack,
  input  logic              prog_busy,
  input  logic              prog_done,
  output logic              pg_to_sp,
  output logic              copy_go,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic              streaming
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  function automatic logic [ADDR_W-1:0] addr_of(input logic [7:0] b);
    return b[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == LAST_ADDR) ? '0 : a + 1'b1;
  endfunction

  scp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    pg_to_sp = 1'b0;
    copy_go  = 1'b0;
    wr_en    = 1'b0;
    if (state_q == ST_PROG) begin
      if (prog_done) state_d = ST_CMD;
    end else if (bus_reset) begin
      state_d = ST_CMD;
    end else begin
      unique case (state_q)
        ST_CMD: if (rx_valid) begin
          unique case (rx_byte)
            OP_READ_MEM: begin pg_to_sp = 1'b1; state_d = ST_RADDR; end
            OP_COPY:     state_d = ST_KEY;
            OP_WRITE_SP: state_d = ST_WADDR;
            OP_READ_SP:  state_d = ST_RADDR;
            default:     state_d = ST_HALT;
          endcase
        end
        ST_KEY: if (rx_valid) begin
          if (rx_byte == COPY_KEY) begin
            copy_go = 1'b1;
            state_d = ST_PROG;
          end else begin
            state_d = ST_CMD;
          end
        end
        ST_RADDR: if (rx_valid) begin
          addr_d  = addr_of(rx_byte);
          state_d = ST_STREAM;
        end
        ST_WADDR: if (rx_valid) begin
          addr_d  = addr_of(rx_byte);
          state_d = ST_WDATA;
        end
        ST_WDATA: if (rx_valid) begin
          wr_en  = 1'b1;
          addr_d = step_addr(addr_q);
        end
        ST_STREAM: if (tx_ack) begin
          addr_d = step_addr(addr_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign addr      = addr_q;
  assign streaming = (state_q == ST_STREAM);

  // R7
  busy_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> (state_q == ST_PROG));

  // R7
  copy_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |=> prog_busy);

  // R3
  stream_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && tx_ack && !bus_reset && addr_q == LAST_ADDR) |=> (addr_q == '0));

  // R10
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !bus_reset) |=> (state_q == ST_HALT));

  // R11
  reset_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && state_q != ST_PROG) |=> (state_q == ST_CMD));

  // R7
  prog_ignores_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && !prog_done) |=> (state_q == ST_PROG));

endmodule

// File: rtl/scratch_eeprom_ctrl.sv
module scratch_eeprom_ctrl #(
  parameter int DEPTH       = 32,
  parameter int PROG_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_ack,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       prog_busy
);

  localparam int ADDR_W = $clog2(DEPTH);

  logic              pg_to_sp;
  logic              copy_go;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic              streaming;
  logic              prog_done;
  logic [7:0]        rd_data;

  scp_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_ack(tx_ack),
    .prog_busy(prog_busy), .prog_done(prog_done),
    .pg_to_sp(pg_to_sp), .copy_go(copy_go), .wr_en(wr_en),
    .addr(addr), .streaming(streaming)
  );

  scp_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pg_to_sp(pg_to_sp), .sp_to_pg(copy_go),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(rx_byte),
    .rd_addr(addr), .rd_data(rd_data)
  );

  scp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(copy_go),
    .busy(prog_busy), .done(prog_done)
  );

  assign tx_valid = streaming;
  assign tx_byte  = streaming ? rd_data : 8'hFF;

  // R11
  no_stream_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> !tx_valid);

endmodule

// File: tb/sim_scratch_eeprom_ctrl.sv
module sim_scratch_eeprom_ctrl;

  localparam int DEPTH = 32;
  localparam int PROGC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_ack = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       prog_busy;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] spad_m [DEPTH];
  logic [7:0] page_m [DEPTH];

  always #5 clk = ~clk;

  scratch_eeprom_ctrl #(.DEPTH(DEPTH), .PROG_CYCLES(PROGC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_ack(tx_ack), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .prog_busy(prog_busy)
  );

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 37 + seed * 11) ^ 8'hC3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic breset();
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  // Reads n bytes and compares against spad_m starting at start.
  task automatic stream(input string tag, input int start, input int n);
    for (int k = 0; k < n; k++) begin
      chk({tag, " data"}, tx_byte, spad_m[(start + k) % DEPTH]);
      tx_ack = 1'b1;
      @(negedge clk);
      tx_ack = 1'b0;
    end
  endtask

  task automatic fill(input int seed);
    send(8'h0F); send(8'h00);
    for (int k = 0; k < DEPTH; k++) begin
      send(pat(k, seed));
      spad_m[k] = pat(k, seed);
    end
    breset();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (prog_busy && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    for (int k = 0; k < DEPTH; k++) begin spad_m[k] = 8'h00; page_m[k] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", prog_busy, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 tx_byte idle", tx_byte, 8'hFF);
    send(8'hAA); send(8'h00);
    chk("R3 tx_valid", tx_valid, 1);
    stream("R1 spad zero", 0, DEPTH);
    breset();

    // R2 write with wrap past 1Fh
    fill(1);
    send(8'h0F); send(8'h1E);
    for (int k = 0; k < 5; k++) begin
      send(pat(k, 2));
      spad_m[(30 + k) % DEPTH] = pat(k, 2);
    end
    breset();
    send(8'hAA); send(8'h00);
    stream("R2 write wrap", 0, DEPTH);
    breset();

    // R4 + R3 upper bits ignored, read wraps
    send(8'hAA); send(8'hFD);
    stream("R4 R3 wrap read", 29, 40);
    breset();
    chk("R11 tx_valid after reset", tx_valid, 0);

    // R6 wrong key, then new command without reset
    send(8'h55); send(8'h5A);
    chk("R6 no busy", prog_busy, 0);
    send(8'hAA); send(8'h03);
    chk("R6 cmd accepted", tx_valid, 1);
    stream("R6 after cancel", 3, 2);
    breset();
    send(8'hF0);
    for (int k = 0; k < DEPTH; k++) spad_m[k] = page_m[k];
    send(8'h00);
    stream("R6 R8 page unchanged", 0, DEPTH);
    breset();

    // R5 R7 valid copy and busy length
    fill(3);
    send(8'h55); send(8'hA5);
    for (int k = 0; k < DEPTH; k++) page_m[k] = spad_m[k];
    chk("R7 busy rises", prog_busy, 1);
    wait_idle(n);
    chk("R7 busy length", n, PROGC);
    fill(4);
    send(8'hF0);
    for (int k = 0; k < DEPTH; k++) spad_m[k] = page_m[k];
    send(8'h07);
    stream("R5 R8 page read", 7, 45);
    breset();

    // R7 interruptions ignored during programming
    fill(5);
    send(8'h55); send(8'hA5);
    for (int k = 0; k < DEPTH; k++) page_m[k] = spad_m[k];
    breset();
    send(8'h0F); send(8'h00); send(8'hEE); send(8'hEE);
    chk("R7 busy held through reset", prog_busy, 1);
    chk("R7 no stream in prog", tx_valid, 0);
    wait_idle(n);
    chk("R7 busy total", n + 5, PROGC);
    send(8'hAA); send(8'h00);
    stream("R7 spad untouched", 0, DEPTH);
    breset();

    // R9 reload with no address byte
    fill(9);
    send(8'hF0);
    breset();
    for (int k = 0; k < DEPTH; k++) spad_m[k] = page_m[k];
    send(8'hAA); send(8'h00);
    stream("R9 reload", 0, DEPTH);
    breset();

    // R10 unknown code parks
    send(8'h33);
    send(8'h0F); send(8'h00); send(8'h11); send(8'h22);
    send(8'hAA); send(8'h00);
    chk("R10 parked no stream", tx_valid, 0);
    send(8'h55); send(8'hA5);
    chk("R10 parked no copy", prog_busy, 0);
    breset();
    send(8'hAA); send(8'h00);
    stream("R10 spad unchanged", 0, 4);

    // R11 reset wins over same-cycle byte
    bus_reset = 1'b1; rx_valid = 1'b1; rx_byte = 8'h33;
    @(negedge clk);
    bus_reset = 1'b0; rx_valid = 1'b0;
    chk("R11 reset drops stream", tx_valid, 0);
    send(8'hAA); send(8'h1F);
    chk("R11 not parked", tx_valid, 1);
    stream("R11 stream", 31, 2);
    breset();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule